// File: doc/BRIEF.md
# Bayer 3x3 Bilinear Color Interpolator

This block rebuilds full RGB values from a raw Bayer mosaic. Three vertically adjacent image lines reach it together: x above, y as the centre line, and z below. On each accepted cycle it takes one column pair (an even column 2p and the odd column 2p+1 next to it) from all three lines. For each column it emits red, green and blue. The colour sampled at that position in the centre line passes straight through. The two missing colours are bilinear averages over the 3x3 neighbourhood.

The equations depend on two things: whether the column is even or odd, and which of two row phases the centre line holds. The phase is set to A on the first line of a frame and alternates on every later line. The block keeps a one-pair window per line, so each pair can see the odd column to its left and the even column to its right. Missing neighbours at either end of a line are copied from the nearest column that exists. A pair is emitted once its right neighbour has arrived. The last pair of a line is emitted on the following cycle by itself.

Input protocol: `sol_i` marks the first pair of a line and `eol_i` the last (both are set on a one-pair line). `sof_i` is asserted together with `sol_i` on the first line of a frame. Every line ends with an `eol_i` pair before the next `sol_i`.

Top module: `bayer_demosaic_3x3`

## Requirements
- R1: Phase A, even column c (index 0 below): R = avg2(y[-1], y[1]), G = y[0], B = avg2(x[0], z[0]).
- R2: Phase A, odd column (index 1, even base 0): R = y[1], G = avg4(x[1], y[0], y[2], z[1]), B = avg4(x[0], x[2], z[0], z[2]).
- R3: Phase B, even column: R = avg4(x[-1], x[1], z[-1], z[1]), G = avg4(x[0], y[-1], y[1], z[0]), B = y[0].
- R4: Phase B, odd column: R = avg2(x[1], z[1]), G = y[1], B = avg2(y[0], y[2]).
- R5: avg2(a,b) = (a+b+1)>>1 and avg4(a,b,c,d) = (a+b+c+d+2)>>2. Sums are 12 bits wide and never wrap, so all-1023 inputs give 1023 on every channel.
- R6: Column -1 of the first pair of a line takes the value of column 0. The column after the last one takes the value of the last (odd) column.
- R7: A line whose first pair carries `sof_i` uses phase A. The first line after reset uses phase A even without `sof_i`. Every other line uses the opposite phase to the line before it.
- R8: A pair that is not the last of its line appears with `out_valid_o` high in the cycle after the next pair of its line is accepted. The last pair appears in the cycle after its own acceptance. There is exactly one output per accepted pair, in order.
- R9: In reset, and in the cycle after it, `out_valid_o` and all colour outputs are 0. A pair still waiting at reset is never emitted. While `in_valid_i` is low, a pair waiting for its right neighbour is not emitted.
- R10: When a line's last pair is being emitted in the same cycle that the next line's first pair is accepted, the last pair still uses its replicated right edge, and the new pair is held with its own replicated left edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | A column pair is presented |
| sof_i | input | 1 | First line of a frame (with sol_i) |
| sol_i | input | 1 | First pair of a line |
| eol_i | input | 1 | Last pair of a line |
| x_even_i | input | 10 | Upper line, even column |
| x_odd_i | input | 10 | Upper line, odd column |
| y_even_i | input | 10 | Centre line, even column |
| y_odd_i | input | 10 | Centre line, odd column |
| z_even_i | input | 10 | Lower line, even column |
| z_odd_i | input | 10 | Lower line, odd column |
| out_valid_o | output | 1 | Colour outputs hold a pair |
| even_r_o | output | 10 | Even column red |
| even_g_o | output | 10 | Even column green |
| even_b_o | output | 10 | Even column blue |
| odd_r_o | output | 10 | Odd column red |
| odd_g_o | output | 10 | Odd column green |
| odd_b_o | output | 10 | Odd column blue |

## Verification
The flush of a line's last pair can fall in the same cycle as the acceptance of the next line's first pair, and so can the phase change. The stimulus table sends lines back to back with no idle cycle between them, including one-pair lines. In those cycles the bench compares the flushed pair against a model that uses the replicated right edge. It then checks that the next pair carries the opposite phase and its own replicated left edge. Each output is also checked for the exact cycle it appears in, and idle gaps inside lines show that a waiting pair is not emitted early.

// File: rtl/bayer_demosaic_pkg.sv
package bayer_demosaic_pkg;
  typedef enum logic {PAT_A = 1'b0, PAT_B = 1'b1} row_pat_e;
  localparam int N_LINES = 3;
  localparam int N_TAPS  = 4;
  // tap slots: column -1, 0, +1, +2 relative to the even column
  localparam int TAP_M1 = 0;
  localparam int TAP_E  = 1;
  localparam int TAP_O  = 2;
  localparam int TAP_P2 = 3;
  localparam int CH_R = 0;
  localparam int CH_G = 1;
  localparam int CH_B = 2;
  localparam int N_CH = 3;
endpackage

// File: rtl/bayer_line_tap.sv
module bayer_line_tap
  import bayer_demosaic_pkg::*;
#(
  parameter int PIX_W = 10
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          load_i,
  input  logic                          sol_i,
  input  logic                          repl_i,
  input  logic [PIX_W-1:0]              even_i,
  input  logic [PIX_W-1:0]              odd_i,
  output logic [N_TAPS-1:0][PIX_W-1:0]  tap_o
);
  logic [PIX_W-1:0] left_q, even_q, odd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      left_q <= '0;
      even_q <= '0;
      odd_q  <= '0;
    end else if (load_i) begin
      // first pair of a line: column -1 copies column 0
      left_q <= sol_i ? even_i : odd_q;
      even_q <= even_i;
      odd_q  <= odd_i;
    end
  end

  always_comb begin
    tap_o[TAP_M1] = left_q;
    tap_o[TAP_E]  = even_q;
    tap_o[TAP_O]  = odd_q;
    tap_o[TAP_P2] = repl_i ? odd_q : even_i;
  end
endmodule

// File: rtl/bayer_pair_kernel.sv
module bayer_pair_kernel
  import bayer_demosaic_pkg::*;
#(
  parameter int PIX_W = 10
) (
  input  row_pat_e                      pat_i,
  input  logic [N_TAPS-1:0][PIX_W-1:0]  x_i,
  input  logic [N_TAPS-1:0][PIX_W-1:0]  y_i,
  input  logic [N_TAPS-1:0][PIX_W-1:0]  z_i,
  output logic [N_CH-1:0][PIX_W-1:0]    even_o,
  output logic [N_CH-1:0][PIX_W-1:0]    odd_o
);
  localparam int SUM_W = PIX_W + 2;

  function automatic logic [PIX_W-1:0] avg2(input logic [PIX_W-1:0] a, input logic [PIX_W-1:0] b);
    logic [SUM_W-1:0] s;
    s = SUM_W'(a) + SUM_W'(b) + SUM_W'(1);
    return s[PIX_W:1];
  endfunction

  function automatic logic [PIX_W-1:0] avg4(input logic [PIX_W-1:0] a, input logic [PIX_W-1:0] b,
                                            input logic [PIX_W-1:0] c, input logic [PIX_W-1:0] d);
    logic [SUM_W-1:0] s;
    s = SUM_W'(a) + SUM_W'(b) + SUM_W'(c) + SUM_W'(d) + SUM_W'(2);
    return s[PIX_W+1:2];
  endfunction

  always_comb begin
    if (pat_i == PAT_A) begin
      even_o[CH_R] = avg2(y_i[TAP_M1], y_i[TAP_O]);
      even_o[CH_G] = y_i[TAP_E];
      even_o[CH_B] = avg2(x_i[TAP_E], z_i[TAP_E]);
      odd_o[CH_R]  = y_i[TAP_O];
      odd_o[CH_G]  = avg4(x_i[TAP_O], y_i[TAP_E], y_i[TAP_P2], z_i[TAP_O]);
      odd_o[CH_B]  = avg4(x_i[TAP_E], x_i[TAP_P2], z_i[TAP_E], z_i[TAP_P2]);
    end else begin
      even_o[CH_R] = avg4(x_i[TAP_M1], x_i[TAP_O], z_i[TAP_M1], z_i[TAP_O]);
      even_o[CH_G] = avg4(x_i[TAP_E], y_i[TAP_M1], y_i[TAP_O], z_i[TAP_E]);
      even_o[CH_B] = y_i[TAP_E];
      odd_o[CH_R]  = avg2(x_i[TAP_O], z_i[TAP_O]);
      odd_o[CH_G]  = y_i[TAP_O];
      odd_o[CH_B]  = avg2(y_i[TAP_E], y_i[TAP_P2]);
    end
  end
endmodule

// File: rtl/bayer_demosaic_3x3.sv
module bayer_demosaic_3x3
  import bayer_demosaic_pkg::*;
#(
  parameter int PIX_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  input  logic             sof_i,
  input  logic             sol_i,
  input  logic             eol_i,
  input  logic [PIX_W-1:0] x_even_i,
  input  logic [PIX_W-1:0] x_odd_i,
  input  logic [PIX_W-1:0] y_even_i,
  input  logic [PIX_W-1:0] y_odd_i,
  input  logic [PIX_W-1:0] z_even_i,
  input  logic [PIX_W-1:0] z_odd_i,
  output logic             out_valid_o,
  output logic [PIX_W-1:0] even_r_o,
  output logic [PIX_W-1:0] even_g_o,
  output logic [PIX_W-1:0] even_b_o,
  output logic [PIX_W-1:0] odd_r_o,
  output logic [PIX_W-1:0] odd_g_o,
  output logic [PIX_W-1:0] odd_b_o
);
  logic [N_LINES-1:0][PIX_W-1:0] ln_even, ln_odd;
  logic [N_LINES-1:0][N_TAPS-1:0][PIX_W-1:0] taps;
  logic [N_CH-1:0][PIX_W-1:0] even_d, odd_d, even_q, odd_q;

  logic     pend_q, last_q, emit, out_valid_q;
  row_pat_e line_pat_q, cur_pat_q, new_pat;

  assign ln_even = {z_even_i, y_even_i, x_even_i};
  assign ln_odd  = {z_odd_i, y_odd_i, x_odd_i};

  // a held pair leaves when its right neighbour arrives or it closes the line
  assign emit = pend_q && (last_q || in_valid_i);

  always_comb begin
    new_pat = line_pat_q;
    if (sol_i) new_pat = sof_i ? PAT_A : row_pat_e'(~line_pat_q);
  end

  for (genvar l = 0; l < N_LINES; l++) begin : g_line
    bayer_line_tap #(.PIX_W(PIX_W)) u_tap (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (in_valid_i),
      .sol_i  (sol_i),
      .repl_i (last_q),
      .even_i (ln_even[l]),
      .odd_i  (ln_odd[l]),
      .tap_o  (taps[l])
    );
  end

  bayer_pair_kernel #(.PIX_W(PIX_W)) u_kernel (
    .pat_i  (cur_pat_q),
    .x_i    (taps[0]),
    .y_i    (taps[1]),
    .z_i    (taps[2]),
    .even_o (even_d),
    .odd_o  (odd_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q     <= 1'b0;
      last_q     <= 1'b0;
      line_pat_q <= PAT_B;  // first line after reset toggles to A
      cur_pat_q  <= PAT_A;
    end else if (in_valid_i) begin
      pend_q     <= 1'b1;
      last_q     <= eol_i;
      line_pat_q <= new_pat;
      cur_pat_q  <= new_pat;
    end else if (emit) begin
      pend_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_q <= 1'b0;
      even_q      <= '0;
      odd_q       <= '0;
    end else begin
      out_valid_q <= emit;
      if (emit) begin
        even_q <= even_d;
        odd_q  <= odd_d;
      end
    end
  end

  assign out_valid_o = out_valid_q;
  assign even_r_o = even_q[CH_R];
  assign even_g_o = even_q[CH_G];
  assign even_b_o = even_q[CH_B];
  assign odd_r_o  = odd_q[CH_R];
  assign odd_g_o  = odd_q[CH_G];
  assign odd_b_o  = odd_q[CH_B];
endmodule

// File: rtl/bayer_demosaic_3x3_chk.sv
module bayer_demosaic_3x3_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic in_valid_i,
  input logic sof_i,
  input logic sol_i,
  input logic pend_q,
  input logic last_q,
  input logic line_pat_q,
  input logic cur_pat_q,
  input logic out_valid_o
);
  // R8
  emit_on_next_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q && in_valid_i |=> out_valid_o);
  // R8
  last_flush_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q && last_q |=> out_valid_o);
  // R9
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pend_q || (!last_q && !in_valid_i)) |=> !out_valid_o);
  // R10
  flush_collide_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q && last_q && in_valid_i |=> out_valid_o && pend_q);
  // R7
  frame_phase_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && sol_i && sof_i |=> !cur_pat_q);
  // R7
  line_toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && sol_i && !sof_i |=> cur_pat_q != $past(line_pat_q));
endmodule

bind bayer_demosaic_3x3 bayer_demosaic_3x3_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .sof_i       (sof_i),
  .sol_i       (sol_i),
  .pend_q      (pend_q),
  .last_q      (last_q),
  .line_pat_q  (line_pat_q),
  .cur_pat_q   (cur_pat_q),
  .out_valid_o (out_valid_o)
);

// File: tb/bayer_demosaic_3x3_tb_top.sv
module bayer_demosaic_3x3_tb_top;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int PIX_W = 10;
  localparam int MAXC  = 16;
  localparam int NVEC  = 8;
  localparam int VEC_SOF  [NVEC] = '{1, 0, 0, 0, 1, 0, 0, 1};
  localparam int VEC_NP   [NVEC] = '{3, 4, 2, 1, 5, 8, 3, 2};
  localparam int VEC_SEED [NVEC] = '{5, 9, 0, 13, 21, 33, 47, 60};
  localparam int VEC_GAP  [NVEC] = '{0, 1, 0, 0, 2, 0, 1, 0};

  logic clk = 1'b0, rst_ni = 1'b0;
  logic in_valid_i = 1'b0, sof_i = 1'b0, sol_i = 1'b0, eol_i = 1'b0;
  logic [PIX_W-1:0] x_even_i = '0, x_odd_i = '0, y_even_i = '0, y_odd_i = '0, z_even_i = '0, z_odd_i = '0;
  logic out_valid_o;
  logic [PIX_W-1:0] even_r_o, even_g_o, even_b_o, odd_r_o, odd_g_o, odd_b_o;

  int checks = 0, errors = 0, cyc = 0;
  int pat_prev = 1;
  int pix [3][MAXC];
  logic [59:0] exp_q [$];
  string req_q [$];
  int cyc_q [$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  bayer_demosaic_3x3 #(.PIX_W(PIX_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .in_valid_i(in_valid_i), .sof_i(sof_i), .sol_i(sol_i), .eol_i(eol_i),
    .x_even_i(x_even_i), .x_odd_i(x_odd_i), .y_even_i(y_even_i), .y_odd_i(y_odd_i),
    .z_even_i(z_even_i), .z_odd_i(z_odd_i), .out_valid_o(out_valid_o),
    .even_r_o(even_r_o), .even_g_o(even_g_o), .even_b_o(even_b_o),
    .odd_r_o(odd_r_o), .odd_g_o(odd_g_o), .odd_b_o(odd_b_o)
  );

  function automatic int a2(int a, int b);
    return (a + b + 1) >> 1;
  endfunction
  function automatic int a4(int a, int b, int c, int d);
    return (a + b + c + d + 2) >> 2;
  endfunction

  function automatic int pixval(int seed, int row, int col);
    if (seed == 0) return 1023;
    return (seed * 131 + row * 277 + col * 59 + col * col * 13 + row * col * 7) % 1024;
  endfunction

  // R6: clamp to the columns that exist
  function automatic int g(int l, int c, int ncol);
    int cc;
    cc = (c < 0) ? 0 : ((c > ncol - 1) ? ncol - 1 : c);
    return pix[l][cc];
  endfunction

  function automatic logic [59:0] model(int pat, int p, int ncol);
    int e, er, eg, eb, orr, og, ob;
    e = 2 * p;
    if (pat == 0) begin
      er = a2(g(1, e-1, ncol), g(1, e+1, ncol)); eg = g(1, e, ncol); eb = a2(g(0, e, ncol), g(2, e, ncol));
      orr = g(1, e+1, ncol);
      og = a4(g(0, e+1, ncol), g(1, e, ncol), g(1, e+2, ncol), g(2, e+1, ncol));
      ob = a4(g(0, e, ncol), g(0, e+2, ncol), g(2, e, ncol), g(2, e+2, ncol));
    end else begin
      er = a4(g(0, e-1, ncol), g(0, e+1, ncol), g(2, e-1, ncol), g(2, e+1, ncol));
      eg = a4(g(0, e, ncol), g(1, e-1, ncol), g(1, e+1, ncol), g(2, e, ncol));
      eb = g(1, e, ncol);
      orr = a2(g(0, e+1, ncol), g(2, e+1, ncol)); og = g(1, e+1, ncol);
      ob = a2(g(1, e, ncol), g(1, e+2, ncol));
    end
    return {er[9:0], eg[9:0], eb[9:0], orr[9:0], og[9:0], ob[9:0]};
  endfunction

  always @(negedge clk) begin
    if (rst_ni && out_valid_o) begin
      logic [59:0] got, e;
      string r;
      int ec;
      got = {even_r_o, even_g_o, even_b_o, odd_r_o, odd_g_o, odd_b_o};
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R8 R9: unexpected output got=%h expected=none", got);
      end else begin
        e = exp_q.pop_front(); r = req_q.pop_front();
        ec = (cyc_q.size() != 0) ? cyc_q.pop_front() : -1;
        checks += 2;
        if (got !== e) begin
          errors++;
          $display("FAIL %s: value got=%h expected=%h", r, got, e);
        end
        if (cyc != ec) begin
          errors++;
          $display("FAIL R8 R10: output cycle got=%0d expected=%0d", cyc, ec);
        end
      end
    end
  end

  task automatic drive_pair(int sof, int sol, int eol, int p);
    @(posedge clk); #1;
    in_valid_i = 1'b1; sof_i = sof[0]; sol_i = sol[0]; eol_i = eol[0];
    x_even_i = pix[0][2*p][9:0]; x_odd_i = pix[0][2*p+1][9:0];
    y_even_i = pix[1][2*p][9:0]; y_odd_i = pix[1][2*p+1][9:0];
    z_even_i = pix[2][2*p][9:0]; z_odd_i = pix[2][2*p+1][9:0];
  endtask

  task automatic idle(int n);
    repeat (n) begin
      @(posedge clk); #1;
      in_valid_i = 1'b0; sof_i = 1'b0; sol_i = 1'b0; eol_i = 1'b0;
    end
  endtask

  task automatic send_line(int sof, int np, int seed, int gap);
    int pat, ncol;
    string base;
    ncol = 2 * np;
    pat = sof ? 0 : (pat_prev ^ 1);
    pat_prev = pat;
    for (int r = 0; r < 3; r++)
      for (int c = 0; c < MAXC; c++) pix[r][c] = pixval(seed, r, c);
    base = (pat == 0) ? "R1 R2 R7" : "R3 R4 R7";
    for (int p = 0; p < np; p++) begin
      string tag;
      tag = base;
      if (p == 0 || p == np - 1) tag = {tag, " R6"};
      if (seed == 0) tag = {tag, " R5"};
      exp_q.push_back(model(pat, p, ncol));
      req_q.push_back(tag);
    end
    for (int p = 0; p < np; p++) begin
      drive_pair(sof && p == 0, p == 0, p == np - 1, p);
      if (p > 0) cyc_q.push_back(cyc + 1);
      if (p == np - 1) cyc_q.push_back(cyc + 2);
      else idle(gap);
    end
  endtask

  initial begin
    #750000;
    checks++; errors++;
    $display("FAIL watchdog: run did not finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (out_valid_o !== 1'b0 || {even_r_o, even_g_o, even_b_o, odd_r_o, odd_g_o, odd_b_o} !== '0) begin
      errors++;
      $display("FAIL R9: reset outputs got=%b/%h expected=0/0", out_valid_o,
               {even_r_o, even_g_o, even_b_o, odd_r_o, odd_g_o, odd_b_o});
    end
    rst_ni = 1'b1;

    for (int v = 0; v < NVEC; v++) send_line(VEC_SOF[v], VEC_NP[v], VEC_SEED[v], VEC_GAP[v]);
    idle(5);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R8: outputs missing got=%0d expected=0", exp_q.size());
    end

    // R9: reset with a pair still waiting; it must never appear
    for (int c = 0; c < MAXC; c++) begin pix[0][c] = 100; pix[1][c] = 200; pix[2][c] = 300; end
    drive_pair(1, 1, 0, 0);
    idle(1);
    @(negedge clk); rst_ni = 1'b0;
    @(negedge clk);
    checks++;
    if (out_valid_o !== 1'b0) begin
      errors++;
      $display("FAIL R9: out_valid in reset got=%b expected=0", out_valid_o);
    end
    @(negedge clk); rst_ni = 1'b1;
    pat_prev = 1;
    idle(3);
    @(negedge clk);
    checks++;
    if (out_valid_o !== 1'b0) begin
      errors++;
      $display("FAIL R9: stale pair after reset got=%b expected=0", out_valid_o);
    end

    // R7: first line after reset without frame start uses phase A
    send_line(0, 2, 77, 0);
    idle(4);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R7 R8: outputs missing got=%0d expected=0", exp_q.size());
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule